// File: doc/BRIEF.md
# Indexed Configuration Port Controller

This block is the configuration register file of a multi-function peripheral controller. It sits on an 8-bit I/O bus and has exactly two addresses: an index port and a data port directly above it. Software writes a register number to the index port. It then reads or writes that register through the data port.

All configuration access is locked after reset. Software opens it by writing an unlock key to the index port, and closes it again with a lock key at the same address. Three registers are global and reachable from any bank: the bank selector, a chip identifier and a revision number. Every other index reaches the bank chosen by the selector.

Device banks (selector values below `NUM_STD_BANKS`) each hold an enable bit, two 16-bit base addresses and two interrupt-line selects. All of these drive output ports for the surrounding address decoders and interrupt routing. The bank whose number equals `NUM_STD_BANKS` holds one 5-bit control byte per general-purpose pin, and these are exported as well.

Top module: `cfgport_ctrl`

## Requirements
- R1: After reset the block is locked, the index and bank selector are 0, `io_rdata` is 0x00, and every exported enable, base, interrupt and pin-control output is 0.
- R2: While locked, every read of the index or data port returns 0xFF. Data-port writes change nothing. Index-port writes other than the unlock key change nothing.
- R3: Writing 0x55 to the index port while locked unlocks the block. Writing 0xAA to it while unlocked locks it again. Neither key write changes the latched index.
- R4: While unlocked, any other index-port write latches the index, and a read of the index port returns it. Read data appears on `io_rdata` from the clock edge that samples `io_rd` and holds until the next read.
- R5: Index 0x07 holds the bank selector and reads back its value. Each device bank keeps its registers apart from the others.
- R6: Index 0x20 reads 0x30 and index 0x21 reads 0x01 whatever the bank selector holds. Writes to both indices have no effect.
- R7: Index 0x30 of a device bank keeps only data bit 0 as the enable. It reads back as 0x00 or 0x01 and drives `dev_active[bank]`.
- R8: Indices 0x60/0x61 hold the high and low bytes of the primary base address. Indices 0x62/0x63 hold those of the secondary base. Each base drives its 16-bit slice of `dev_pri_base` or `dev_sec_base`.
- R9: Indices 0x70 and 0x72 hold the primary and secondary interrupt selects. Each keeps the low `IRQ_W` (default 4) data bits, reads back zero-extended and drives its export.
- R10: In the pin-control bank (selector 8 by default), index 0xC0+k holds the control byte of pin k. Bit 0 is direction (1 = input), bit 1 is invert, bit 2 is interrupt enable, and bits 4:3 are the function select. Bits 7:5 read 0.
- R11: While unlocked, an index implemented by neither the global set nor the selected bank reads 0x00 and ignores writes. Selector values above the pin-control bank reach no bank.
- R12: Bus accesses to any address other than the two ports are ignored, and a read of such an address returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | IO_AW | I/O bus address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| dev_active | output | NUM_STD_BANKS | Enable bit of each device bank |
| dev_pri_base | output | NUM_STD_BANKS*16 | Primary base per bank, bank b at bits [16b+15:16b] |
| dev_sec_base | output | NUM_STD_BANKS*16 | Secondary base per bank |
| dev_pri_irq | output | NUM_STD_BANKS*IRQ_W | Primary interrupt select per bank |
| dev_sec_irq | output | NUM_STD_BANKS*IRQ_W | Secondary interrupt select per bank |
| gpio_dir | output | NUM_GPIO | Pin direction, 1 = input |
| gpio_inv | output | NUM_GPIO | Pin polarity invert |
| gpio_irq_en | output | NUM_GPIO | Pin combined-interrupt enable |
| gpio_func | output | NUM_GPIO*2 | Pin function select, pin k at bits [2k+1:2k] |

## Verification
A write strobe presented in one cycle is taken at the next rising edge. Every export, and the lock state, changes at that same edge. A read strobe is sampled at one edge, and the value appears on `io_rdata` right after it. The bench drives each strobe for one cycle from a falling edge and samples one falling edge later, which is half a cycle after the edge that registers the result. The export checks come after the whole write sequence has settled, and the reset checks come after the reset edge.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    // Global register indices (reachable from every bank)
    localparam logic [7:0] IDX_BANK_SEL  = 8'h07;
    localparam logic [7:0] IDX_CHIP_ID   = 8'h20;
    localparam logic [7:0] IDX_CHIP_REV  = 8'h21;

    // Per-device bank register indices
    localparam logic [7:0] IDX_ENABLE    = 8'h30;
    localparam logic [7:0] IDX_PBASE_HI  = 8'h60;
    localparam logic [7:0] IDX_PBASE_LO  = 8'h61;
    localparam logic [7:0] IDX_SBASE_HI  = 8'h62;
    localparam logic [7:0] IDX_SBASE_LO  = 8'h63;
    localparam logic [7:0] IDX_PIRQ      = 8'h70;
    localparam logic [7:0] IDX_SIRQ      = 8'h72;

    // Values returned when nothing drives the bus / nothing is mapped
    localparam logic [7:0] BUS_FLOAT     = 8'hFF;
    localparam logic [7:0] UNMAPPED      = 8'h00;

    // Pin control byte layout
    localparam int PIN_DIR_BIT = 0;
    localparam int PIN_INV_BIT = 1;
    localparam int PIN_IEN_BIT = 2;
    localparam int PIN_FN_LSB  = 3;
    localparam int PIN_CFG_W   = 5;

    typedef struct packed {
        logic [7:0] idx;
        logic [7:0] bank;
        logic [7:0] rdata;
    } port_state_t;

endpackage

// File: rtl/cfgport_keylock.sv
module cfgport_keylock #(
    parameter logic [7:0] KEY_ON  = 8'h55,
    parameter logic [7:0] KEY_OFF = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked,
    output logic       idx_load
);

    typedef enum logic {MODE_RUN, MODE_CFG} mode_e;

    mode_e mode_d, mode_q;

    always_comb begin
        mode_d   = mode_q;
        idx_load = 1'b0;
        if (idx_wr) begin
            case (mode_q)
                MODE_RUN: begin
                    if (wdata == KEY_ON) mode_d = MODE_CFG;
                end
                MODE_CFG: begin
                    if (wdata == KEY_OFF) mode_d = MODE_RUN;
                    else                  idx_load = 1'b1;
                end
                default: mode_d = MODE_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_RUN;
        else        mode_q <= mode_d;
    end

    assign unlocked = (mode_q == MODE_CFG);

endmodule

// File: rtl/cfgport_dev_bank.sv
module cfgport_dev_bank
    import cfgport_pkg::*;
#(
    parameter int IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       idx,
    input  logic [7:0]       wdata,
    output logic             active,
    output logic [15:0]      pri_base,
    output logic [15:0]      sec_base,
    output logic [IRQ_W-1:0] pri_irq,
    output logic [IRQ_W-1:0] sec_irq,
    output logic [7:0]       rd_data
);

    localparam int IRQ_PAD = 8 - IRQ_W;

    typedef struct packed {
        logic             en;
        logic [15:0]      pbase;
        logic [15:0]      sbase;
        logic [IRQ_W-1:0] pirq;
        logic [IRQ_W-1:0] sirq;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            case (idx)
                IDX_ENABLE:   bank_d.en          = wdata[0];
                IDX_PBASE_HI: bank_d.pbase[15:8] = wdata;
                IDX_PBASE_LO: bank_d.pbase[7:0]  = wdata;
                IDX_SBASE_HI: bank_d.sbase[15:8] = wdata;
                IDX_SBASE_LO: bank_d.sbase[7:0]  = wdata;
                IDX_PIRQ:     bank_d.pirq        = wdata[IRQ_W-1:0];
                IDX_SIRQ:     bank_d.sirq        = wdata[IRQ_W-1:0];
                default:      ;
            endcase
        end
    end

    always_comb begin
        case (idx)
            IDX_ENABLE:   rd_data = {7'b0, bank_q.en};
            IDX_PBASE_HI: rd_data = bank_q.pbase[15:8];
            IDX_PBASE_LO: rd_data = bank_q.pbase[7:0];
            IDX_SBASE_HI: rd_data = bank_q.sbase[15:8];
            IDX_SBASE_LO: rd_data = bank_q.sbase[7:0];
            IDX_PIRQ:     rd_data = {{IRQ_PAD{1'b0}}, bank_q.pirq};
            IDX_SIRQ:     rd_data = {{IRQ_PAD{1'b0}}, bank_q.sirq};
            default:      rd_data = UNMAPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign active   = bank_q.en;
    assign pri_base = bank_q.pbase;
    assign sec_base = bank_q.sbase;
    assign pri_irq  = bank_q.pirq;
    assign sec_irq  = bank_q.sirq;

endmodule

// File: rtl/cfgport_pin_bank.sv
module cfgport_pin_bank
    import cfgport_pkg::*;
#(
    parameter int         NUM_GPIO = 48,
    parameter logic [7:0] IDX_BASE = 8'hC0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            idx,
    input  logic [PIN_CFG_W-1:0]  wdata,
    output logic [NUM_GPIO-1:0]   pin_dir,
    output logic [NUM_GPIO-1:0]   pin_inv,
    output logic [NUM_GPIO-1:0]   pin_ien,
    output logic [2*NUM_GPIO-1:0] pin_func,
    output logic [7:0]            rd_data
);

    localparam int RD_PAD = 8 - PIN_CFG_W;

    logic [PIN_CFG_W-1:0] cfg_d [NUM_GPIO];
    logic [PIN_CFG_W-1:0] cfg_q [NUM_GPIO];
    logic [NUM_GPIO-1:0]  hit;

    for (genvar k = 0; k < NUM_GPIO; k++) begin : g_pin
        assign hit[k]           = (idx == 8'(int'(IDX_BASE) + k));
        assign pin_dir[k]       = cfg_q[k][PIN_DIR_BIT];
        assign pin_inv[k]       = cfg_q[k][PIN_INV_BIT];
        assign pin_ien[k]       = cfg_q[k][PIN_IEN_BIT];
        assign pin_func[2*k +: 2] = cfg_q[k][PIN_FN_LSB +: 2];
    end

    always_comb begin
        rd_data = UNMAPPED;
        for (int k = 0; k < NUM_GPIO; k++) begin
            cfg_d[k] = cfg_q[k];
            if (wr_en && hit[k]) cfg_d[k] = wdata;
            if (hit[k]) rd_data = {{RD_PAD{1'b0}}, cfg_q[k]};
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NUM_GPIO; k++) begin
            if (!rst_n) cfg_q[k] <= '0;
            else        cfg_q[k] <= cfg_d[k];
        end
    end

endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
    import cfgport_pkg::*;
#(
    parameter int              IO_AW         = 16,
    parameter logic [IO_AW-1:0] IDX_PORT     = 16'h03F0,
    parameter int              NUM_STD_BANKS = 8,
    parameter int              IRQ_W         = 4,
    parameter int              NUM_GPIO      = 48,
    parameter logic [7:0]      PIN_IDX_BASE  = 8'hC0,
    parameter logic [7:0]      CHIP_ID       = 8'h30,
    parameter logic [7:0]      CHIP_REV      = 8'h01,
    parameter logic [7:0]      KEY_ON        = 8'h55,
    parameter logic [7:0]      KEY_OFF       = 8'hAA
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [IO_AW-1:0]               io_addr,
    input  logic                           io_wr,
    input  logic                           io_rd,
    input  logic [7:0]                     io_wdata,
    output logic [7:0]                     io_rdata,
    output logic [NUM_STD_BANKS-1:0]       dev_active,
    output logic [NUM_STD_BANKS*16-1:0]    dev_pri_base,
    output logic [NUM_STD_BANKS*16-1:0]    dev_sec_base,
    output logic [NUM_STD_BANKS*IRQ_W-1:0] dev_pri_irq,
    output logic [NUM_STD_BANKS*IRQ_W-1:0] dev_sec_irq,
    output logic [NUM_GPIO-1:0]            gpio_dir,
    output logic [NUM_GPIO-1:0]            gpio_inv,
    output logic [NUM_GPIO-1:0]            gpio_irq_en,
    output logic [NUM_GPIO*2-1:0]          gpio_func
);

    localparam logic [IO_AW-1:0] DATA_PORT = IDX_PORT + 1'b1;
    localparam logic [7:0]       PIN_BANK  = 8'(NUM_STD_BANKS);

    port_state_t st_d, st_q;

    logic       at_idx, at_data;
    logic       unlocked, idx_load;
    logic       data_wr;
    logic [7:0] bank_rd [NUM_STD_BANKS];
    logic [7:0] pin_rd;
    logic [7:0] rd_mux;

    assign at_idx  = (io_addr == IDX_PORT);
    assign at_data = (io_addr == DATA_PORT);
    assign data_wr = io_wr && at_data && unlocked;

    cfgport_keylock #(
        .KEY_ON  (KEY_ON),
        .KEY_OFF (KEY_OFF)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (io_wr && at_idx),
        .wdata    (io_wdata),
        .unlocked (unlocked),
        .idx_load (idx_load)
    );

    for (genvar b = 0; b < NUM_STD_BANKS; b++) begin : g_bank
        cfgport_dev_bank #(
            .IRQ_W (IRQ_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (data_wr && (st_q.bank == 8'(b))),
            .idx      (st_q.idx),
            .wdata    (io_wdata),
            .active   (dev_active[b]),
            .pri_base (dev_pri_base[b*16 +: 16]),
            .sec_base (dev_sec_base[b*16 +: 16]),
            .pri_irq  (dev_pri_irq[b*IRQ_W +: IRQ_W]),
            .sec_irq  (dev_sec_irq[b*IRQ_W +: IRQ_W]),
            .rd_data  (bank_rd[b])
        );
    end

    cfgport_pin_bank #(
        .NUM_GPIO (NUM_GPIO),
        .IDX_BASE (PIN_IDX_BASE)
    ) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (data_wr && (st_q.bank == PIN_BANK)),
        .idx      (st_q.idx),
        .wdata    (io_wdata[PIN_CFG_W-1:0]),
        .pin_dir  (gpio_dir),
        .pin_inv  (gpio_inv),
        .pin_ien  (gpio_irq_en),
        .pin_func (gpio_func),
        .rd_data  (pin_rd)
    );

    // Read-back selection
    always_comb begin
        rd_mux = BUS_FLOAT;
        if (at_idx) begin
            if (unlocked) rd_mux = st_q.idx;
        end else if (at_data && unlocked) begin
            case (st_q.idx)
                IDX_BANK_SEL: rd_mux = st_q.bank;
                IDX_CHIP_ID:  rd_mux = CHIP_ID;
                IDX_CHIP_REV: rd_mux = CHIP_REV;
                default: begin
                    rd_mux = UNMAPPED;
                    for (int b = 0; b < NUM_STD_BANKS; b++) begin
                        if (st_q.bank == 8'(b)) rd_mux = bank_rd[b];
                    end
                    if (st_q.bank == PIN_BANK) rd_mux = pin_rd;
                end
            endcase
        end
    end

    // Next-state computation
    always_comb begin
        st_d = st_q;
        if (idx_load) st_d.idx = io_wdata;
        if (data_wr && (st_q.idx == IDX_BANK_SEL)) st_d.bank = io_wdata;
        if (io_rd) st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign io_rdata = st_q.rdata;

endmodule

// File: rtl/cfgport_ctrl_chk.sv
module cfgport_ctrl_chk #(
    parameter int               IO_AW         = 16,
    parameter logic [IO_AW-1:0] IDX_PORT      = 16'h03F0,
    parameter int               NUM_STD_BANKS = 8,
    parameter int               NUM_GPIO      = 48,
    parameter logic [7:0]       CHIP_ID       = 8'h30,
    parameter logic [7:0]       KEY_ON        = 8'h55,
    parameter logic [7:0]       KEY_OFF       = 8'hAA
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [IO_AW-1:0]         io_addr,
    input logic                     io_wr,
    input logic                     io_rd,
    input logic [7:0]               io_wdata,
    input logic [7:0]               io_rdata,
    input logic                     unlocked,
    input logic [7:0]               cur_idx,
    input logic [NUM_STD_BANKS-1:0] dev_active,
    input logic [NUM_GPIO-1:0]      gpio_dir
);

    localparam logic [IO_AW-1:0] DATA_PORT = IDX_PORT + 1'b1;

    // R2: a read while locked always returns the floating-bus value
    a_r2_locked_read_float: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd && !unlocked |=> io_rdata == 8'hFF);

    // R2: nothing exported can move while locked
    a_r2_locked_exports_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(dev_active) && $stable(gpio_dir));

    // R3: unlock key opens configuration mode
    a_r3_unlock_key: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked && io_wr && io_addr == IDX_PORT && io_wdata == KEY_ON |=> unlocked);

    // R3: lock key closes configuration mode and leaves the index alone
    a_r3_lock_key: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked && io_wr && io_addr == IDX_PORT && io_wdata == KEY_OFF
        |=> !unlocked && cur_idx == $past(cur_idx));

    // R4: index port reads return the latched index
    a_r4_index_readback: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked && io_rd && io_addr == IDX_PORT |=> io_rdata == $past(cur_idx));

    // R6: identifier index always returns the chip identifier
    a_r6_chip_id: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked && io_rd && io_addr == DATA_PORT && cur_idx == 8'h20 |=> io_rdata == CHIP_ID);

    // R12: foreign addresses read as a floating bus
    a_r12_foreign_read: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd && io_addr != IDX_PORT && io_addr != DATA_PORT |=> io_rdata == 8'hFF);

endmodule

bind cfgport_ctrl cfgport_ctrl_chk #(
    .IO_AW         (IO_AW),
    .IDX_PORT      (IDX_PORT),
    .NUM_STD_BANKS (NUM_STD_BANKS),
    .NUM_GPIO      (NUM_GPIO),
    .CHIP_ID       (CHIP_ID),
    .KEY_ON        (KEY_ON),
    .KEY_OFF       (KEY_OFF)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .unlocked   (unlocked),
    .cur_idx    (st_q.idx),
    .dev_active (dev_active),
    .gpio_dir   (gpio_dir)
);

// File: tb/tb_cfgport_ctrl.sv
`timescale 1ns/1ps
module tb_cfgport_ctrl;

    localparam int NB = 8;
    localparam int IW = 4;
    localparam int NG = 48;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       io_addr = '0;
    logic              io_wr = 1'b0;
    logic              io_rd = 1'b0;
    logic [7:0]        io_wdata = '0;
    logic [7:0]        io_rdata;
    logic [NB-1:0]     dev_active;
    logic [NB*16-1:0]  dev_pri_base, dev_sec_base;
    logic [NB*IW-1:0]  dev_pri_irq, dev_sec_irq;
    logic [NG-1:0]     gpio_dir, gpio_inv, gpio_irq_en;
    logic [NG*2-1:0]   gpio_func;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cfgport_ctrl dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_active(dev_active),
        .dev_pri_base(dev_pri_base), .dev_sec_base(dev_sec_base),
        .dev_pri_irq(dev_pri_irq), .dev_sec_irq(dev_sec_irq),
        .gpio_dir(gpio_dir), .gpio_inv(gpio_inv), .gpio_irq_en(gpio_irq_en),
        .gpio_func(gpio_func)
    );

    // Vector: {op, addr, value, requirement}; op 0 = write, 1 = read and compare
    localparam int NV = 74;
    localparam logic [39:0] VEC [NV] = '{
        {8'd1, 16'h03F1, 8'hFF, 8'd2},  // R2 locked data read
        {8'd1, 16'h03F0, 8'hFF, 8'd2},  // R2 locked index read
        {8'd0, 16'h03F0, 8'h20, 8'd2},  // R2 non-key index write ignored
        {8'd0, 16'h03F1, 8'hAA, 8'd2},  // R2 locked data write ignored
        {8'd0, 16'h03F0, 8'h55, 8'd3},  // R3 unlock
        {8'd1, 16'h03F0, 8'h00, 8'd3},  // R3 index untouched by key
        {8'd0, 16'h03F0, 8'h20, 8'd4},
        {8'd1, 16'h03F0, 8'h20, 8'd4},  // R4 index readback
        {8'd1, 16'h03F1, 8'h30, 8'd6},  // R6 chip id
        {8'd0, 16'h03F0, 8'h21, 8'd6},
        {8'd1, 16'h03F1, 8'h01, 8'd6},  // R6 revision
        {8'd0, 16'h03F1, 8'h77, 8'd6},
        {8'd1, 16'h03F1, 8'h01, 8'd6},  // R6 read-only
        {8'd0, 16'h03F0, 8'h07, 8'd5},
        {8'd0, 16'h03F1, 8'h04, 8'd5},
        {8'd1, 16'h03F1, 8'h04, 8'd5},  // R5 selector readback
        {8'd0, 16'h03F0, 8'h30, 8'd7},
        {8'd0, 16'h03F1, 8'h03, 8'd7},
        {8'd1, 16'h03F1, 8'h01, 8'd7},  // R7 only bit 0 kept
        {8'd0, 16'h03F0, 8'h60, 8'd8},
        {8'd0, 16'h03F1, 8'h03, 8'd8},
        {8'd0, 16'h03F0, 8'h61, 8'd8},
        {8'd0, 16'h03F1, 8'hF8, 8'd8},
        {8'd1, 16'h03F1, 8'hF8, 8'd8},  // R8 primary low
        {8'd0, 16'h03F0, 8'h60, 8'd8},
        {8'd1, 16'h03F1, 8'h03, 8'd8},  // R8 primary high
        {8'd0, 16'h03F0, 8'h62, 8'd8},
        {8'd0, 16'h03F1, 8'h01, 8'd8},
        {8'd0, 16'h03F0, 8'h63, 8'd8},
        {8'd0, 16'h03F1, 8'h23, 8'd8},
        {8'd1, 16'h03F1, 8'h23, 8'd8},  // R8 secondary low
        {8'd0, 16'h03F0, 8'h70, 8'd9},
        {8'd0, 16'h03F1, 8'hFC, 8'd9},
        {8'd1, 16'h03F1, 8'h0C, 8'd9},  // R9 truncated primary irq
        {8'd0, 16'h03F0, 8'h72, 8'd9},
        {8'd0, 16'h03F1, 8'h05, 8'd9},
        {8'd1, 16'h03F1, 8'h05, 8'd9},  // R9 secondary irq
        {8'd0, 16'h03F0, 8'h07, 8'd5},
        {8'd0, 16'h03F1, 8'h05, 8'd5},
        {8'd0, 16'h03F0, 8'h30, 8'd5},
        {8'd1, 16'h03F1, 8'h00, 8'd5},  // R5 bank 5 apart from bank 4
        {8'd0, 16'h03F0, 8'h60, 8'd8},
        {8'd0, 16'h03F1, 8'h02, 8'd8},
        {8'd0, 16'h03F0, 8'h61, 8'd8},
        {8'd0, 16'h03F1, 8'hF8, 8'd8},
        {8'd0, 16'h03F0, 8'h07, 8'd10},
        {8'd0, 16'h03F1, 8'h08, 8'd10},
        {8'd0, 16'h03F0, 8'hC5, 8'd10},
        {8'd0, 16'h03F1, 8'hFF, 8'd10},
        {8'd1, 16'h03F1, 8'h1F, 8'd10}, // R10 upper bits read 0
        {8'd0, 16'h03F0, 8'hEF, 8'd10},
        {8'd0, 16'h03F1, 8'h09, 8'd10},
        {8'd1, 16'h03F1, 8'h09, 8'd10}, // R10 last pin
        {8'd0, 16'h03F0, 8'h55, 8'd11},
        {8'd0, 16'h03F1, 8'h12, 8'd11},
        {8'd1, 16'h03F1, 8'h00, 8'd11}, // R11 unmapped index
        {8'd0, 16'h03F0, 8'h07, 8'd11},
        {8'd0, 16'h03F1, 8'h0A, 8'd11},
        {8'd0, 16'h03F0, 8'h30, 8'd11},
        {8'd0, 16'h03F1, 8'h01, 8'd11},
        {8'd1, 16'h03F1, 8'h00, 8'd11}, // R11 selector past last bank
        {8'd0, 16'h03F0, 8'h20, 8'd6},
        {8'd1, 16'h03F1, 8'h30, 8'd6},  // R6 global under any selector
        {8'd1, 16'h02F8, 8'hFF, 8'd12}, // R12 foreign read
        {8'd0, 16'h03F2, 8'h07, 8'd12},
        {8'd1, 16'h03F0, 8'h20, 8'd12}, // R12 foreign write ignored
        {8'd0, 16'h03F0, 8'hAA, 8'd3},
        {8'd1, 16'h03F0, 8'hFF, 8'd3},  // R3 locked again
        {8'd0, 16'h03F0, 8'h07, 8'd2},
        {8'd0, 16'h03F1, 8'h03, 8'd2},
        {8'd0, 16'h03F0, 8'h55, 8'd3},
        {8'd1, 16'h03F0, 8'h20, 8'd3},  // R3 index held across lock
        {8'd0, 16'h03F0, 8'h07, 8'd2},
        {8'd1, 16'h03F1, 8'h0A, 8'd2}   // R2 locked writes changed nothing
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", 32'(io_rdata), 32'h00);
        check("R1 active", 32'(dev_active), 32'h0);
        check("R1 bases", 32'(|{dev_pri_base, dev_sec_base, dev_pri_irq, dev_sec_irq}), 32'h0);
        check("R1 pins", 32'(|{gpio_dir, gpio_inv, gpio_irq_en, gpio_func}), 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][39:32] == 8'd0) begin
                bus_wr(VEC[i][31:16], VEC[i][15:8]);
            end else begin
                bus_rd(VEC[i][31:16], rv);
                check($sformatf("R%0d vector %0d", VEC[i][7:0], i), 32'(rv), 32'(VEC[i][15:8]));
            end
        end

        // Exports after the sequence
        check("R7 active", 32'(dev_active), 32'h10);
        check("R8 pri base 4", 32'(dev_pri_base[4*16 +: 16]), 32'h03F8);
        check("R8 pri base 5", 32'(dev_pri_base[5*16 +: 16]), 32'h02F8);
        check("R8 sec base 4", 32'(dev_sec_base[4*16 +: 16]), 32'h0123);
        check("R9 pri irq 4", 32'(dev_pri_irq[4*IW +: IW]), 32'hC);
        check("R9 sec irq 4", 32'(dev_sec_irq[4*IW +: IW]), 32'h5);
        check("R10 pin5", 32'({gpio_func[10 +: 2], gpio_irq_en[5], gpio_inv[5], gpio_dir[5]}), 32'h1F);
        check("R10 pin47", 32'({gpio_func[94 +: 2], gpio_irq_en[47], gpio_inv[47], gpio_dir[47]}), 32'h09);
        check("R10 pin0", 32'({gpio_func[0 +: 2], gpio_irq_en[0], gpio_inv[0], gpio_dir[0]}), 32'h00);

        // R1 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 active after reset", 32'(dev_active), 32'h0);
        check("R1 pins after reset", 32'(|{gpio_dir, gpio_func, dev_pri_base}), 32'h0);
        bus_rd(16'h03F1, rv);
        check("R1 locked after reset", 32'(rv), 32'hFF);
        bus_wr(16'h03F0, 8'h55);
        bus_rd(16'h03F0, rv);
        check("R1 index after reset", 32'(rv), 32'h00);
        bus_wr(16'h03F0, 8'h07);
        bus_rd(16'h03F1, rv);
        check("R1 selector after reset", 32'(rv), 32'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule